// File: doc/BRIEF.md
# PWM Fault Override Output Stage

This block sits between a three-pair PWM generator and the package pins. Each pair has a high-side and a low-side signal. For every pin the block applies a polarity and an output enable. It also watches an asynchronous, active-low fault input that can force chosen pairs to programmed levels. The raw PWM bits use 1 to mean "active". The block turns them into pin levels through the two polarity inputs: one for every high-side pin and one for every low-side pin. It registers the pin values and the tri-state controls.

The fault input goes through a synchronizer. Its falling edge sets an interrupt flag, and software clears the flag with a write-one-to-clear strobe. A mode bit selects one of two release rules. In latched mode the override holds until the pin is high and the flag is clear. In cycle-by-cycle mode it holds only while the pin is low. In both modes the outputs return to normal only on a PWM cycle or half-cycle boundary strobe. A complementary-mode bit stops both pins of a pair from being forced active at the same time.

Top module: `pwm_fault_stage`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `pin_oe` is all 0 if `rst_tristate` is 1 and all 1 if it is 0. `pin_out` holds each pin's inactive level. The pin enables reset to the inverse of `rst_tristate`.
- R2: With no fault override, each pin is registered one clock after its raw bit. The pin is driven to its polarity level (`pol_hi` for the high side, `pol_lo` for the low side) when the raw bit is 1, and to the inverse when it is 0. Pin index 2p is the high side of pair p and index 2p+1 is its low side.
- R3: A pin whose enable bit is 0 has `pin_oe` 0 and `pin_out` at its inactive level, one clock after the enable register changes. A `cfg_we` pulse loads all configuration registers in one clock.
- R4: Only pairs whose bit is set in `cfg_flt_pair_en` are overridden. With all three bits clear, a fault leaves every pin on its normal path.
- R5: During an override, a fault-level bit of 1 drives the pin active and 0 drives it inactive, both through that pin's polarity. The forced level appears on the third rising edge after `fault_n` falls.
- R6: With `cfg_comp` set and both fault-level bits of a pair set, the high side is driven active and the low side inactive.
- R7: In latched mode (`cfg_latched` = 1), normal output returns only after `fault_n` is high, the flag is clear, and a boundary strobe is seen. Output is normal on the edge after that boundary.
- R8: In latched mode, clearing the flag while `fault_n` is still low keeps the override in force, even across boundaries, until the pin is high and a later boundary arrives.
- R9: In cycle-by-cycle mode (`cfg_latched` = 0), the override holds while the pin is low, and after the pin goes high until a boundary strobe. The state of the flag has no effect.
- R10: A falling edge of the synchronized fault input sets `flt_flag` whatever the pair enables are. A `flag_clr` pulse clears it. If a set and a clear fall in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_tristate | input | 1 | Reset option: 1 tri-states all pins, 0 drives them inactive |
| pol_hi | input | 1 | Active level of all high-side pins |
| pol_lo | input | 1 | Active level of all low-side pins |
| pwm_raw | input | 6 | Raw PWM bits, 1 = active, index 2p high / 2p+1 low |
| pwm_bnd | input | 1 | PWM cycle or half-cycle boundary strobe |
| fault_n | input | 1 | Asynchronous active-low fault pin |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_pin_en | input | 6 | Per-pin output enables |
| cfg_flt_pair_en | input | 3 | Per-pair fault override enables |
| cfg_flt_lvl | input | 6 | Per-pin forced level on fault, 1 = active |
| cfg_latched | input | 1 | 1 = latched fault mode, 0 = cycle-by-cycle |
| cfg_comp | input | 1 | Complementary-pair priority on fault |
| flag_clr | input | 1 | Write-one-to-clear strobe for the fault flag |
| pin_out | output | 6 | Registered pin levels |
| pin_oe | output | 6 | Registered output enables, 0 = released |
| flt_flag | output | 1 | Fault interrupt flag |

## Verification
Two pairs of events can land in the same clock. The first is a synchronized falling edge of the fault pin together with a flag-clear strobe. The bench drives `fault_n` low, then raises `flag_clr` in exactly the cycle where the edge reaches the flag logic. It expects the flag to stay set. The second is a boundary strobe that arrives while a release condition is still missing: the pin is still low, or in latched mode the flag is still set. The bench pulses the boundary in each of those states and expects the forced levels to stay on the pins. It then expects them to drop on the edge after the first boundary where every condition holds.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  typedef enum logic {
    MODE_CYCLE   = 1'b0,
    MODE_LATCHED = 1'b1
  } flt_mode_e;

  function automatic logic pin_level(input logic active, input logic pol);
    return active ? pol : ~pol;
  endfunction

endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_n,
  output logic sync_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], async_n};
  end

  assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/pfs_fault_ctrl.sv
module pfs_fault_ctrl
  import pfs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      flt_n_s,
  input  logic      bnd,
  input  flt_mode_e mode,
  input  logic      flag_clr,
  output logic      flag,
  output logic      apply
);
  logic flt_n_d;
  logic ovr_q;
  logic fall;
  logic flt_low;
  logic release_ok;

  assign flt_low    = ~flt_n_s;
  assign fall       = flt_n_d & ~flt_n_s;
  assign release_ok = bnd & ~flt_low & ((mode == MODE_CYCLE) | ~flag);
  assign apply      = flt_low | ovr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flt_n_d <= 1'b1;
      flag    <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      flt_n_d <= flt_n_s;
      if (fall)          flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      if (flt_low)         ovr_q <= 1'b1;
      else if (release_ok) ovr_q <= 1'b0;
    end
  end

  // R10: a synchronized falling edge always sets the flag
  p_flag_set_r10: assert property (@(posedge clk) disable iff (rst)
    fall |=> flag);
  // R10: a clear without a simultaneous edge empties the flag
  p_flag_clr_r10: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !fall) |=> !flag);
  // R9: no release away from a boundary
  p_hold_off_bnd_r9: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !bnd) |=> ovr_q);
  // R7: latched override stays while the flag is set
  p_latched_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_LATCHED && ovr_q && flag) |=> ovr_q);
  // R8: a low fault pin always keeps the override
  p_low_holds_r8: assert property (@(posedge clk) disable iff (rst)
    flt_low |=> ovr_q);
endmodule

// File: rtl/pfs_pair_mux.sv
module pfs_pair_mux
  import pfs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rst_tristate,
  input  logic pol_h,
  input  logic pol_l,
  input  logic raw_h,
  input  logic raw_l,
  input  logic en_h,
  input  logic en_l,
  input  logic ovr,
  input  logic lvl_h,
  input  logic lvl_l,
  input  logic comp,
  output logic out_h,
  output logic out_l,
  output logic oe_h,
  output logic oe_l
);
  logic act_h, act_l;

  assign act_h = ovr ? lvl_h : raw_h;
  assign act_l = ovr ? (lvl_l & ~(comp & lvl_h)) : raw_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_h <= ~pol_h;
      out_l <= ~pol_l;
      oe_h  <= ~rst_tristate;
      oe_l  <= ~rst_tristate;
    end else begin
      oe_h  <= en_h;
      oe_l  <= en_l;
      out_h <= pin_level(en_h & act_h, pol_h);
      out_l <= pin_level(en_l & act_l, pol_l);
    end
  end

  // R6: complementary priority keeps the low side inactive
  p_comp_prio_r6: assert property (@(posedge clk) disable iff (rst)
    (ovr && comp && lvl_h && lvl_l) |=> (out_l == ~$past(pol_l)));
  // R3: disabled pin is released
  p_disabled_hi_r3: assert property (@(posedge clk) disable iff (rst)
    !en_h |=> !oe_h);
  p_disabled_lo_r3: assert property (@(posedge clk) disable iff (rst)
    !en_l |=> !oe_l);
endmodule

// File: rtl/pwm_fault_stage.sv
module pwm_fault_stage
  import pfs_pkg::*;
#(
  parameter int NPAIR       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rst_tristate,
  input  logic               pol_hi,
  input  logic               pol_lo,
  input  logic [2*NPAIR-1:0] pwm_raw,
  input  logic               pwm_bnd,
  input  logic               fault_n,
  input  logic               cfg_we,
  input  logic [2*NPAIR-1:0] cfg_pin_en,
  input  logic [NPAIR-1:0]   cfg_flt_pair_en,
  input  logic [2*NPAIR-1:0] cfg_flt_lvl,
  input  logic               cfg_latched,
  input  logic               cfg_comp,
  input  logic               flag_clr,
  output logic [2*NPAIR-1:0] pin_out,
  output logic [2*NPAIR-1:0] pin_oe,
  output logic               flt_flag
);
  localparam int NPIN = 2 * NPAIR;

  logic [NPIN-1:0]  pin_en_q;
  logic [NPAIR-1:0] pair_en_q;
  logic [NPIN-1:0]  lvl_q;
  flt_mode_e        mode_q;
  logic             comp_q;
  logic             flt_n_s;
  logic             apply;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_en_q  <= {NPIN{~rst_tristate}};
      pair_en_q <= '0;
      lvl_q     <= '0;
      mode_q    <= MODE_CYCLE;
      comp_q    <= 1'b0;
    end else if (cfg_we) begin
      pin_en_q  <= cfg_pin_en;
      pair_en_q <= cfg_flt_pair_en;
      lvl_q     <= cfg_flt_lvl;
      mode_q    <= flt_mode_e'(cfg_latched);
      comp_q    <= cfg_comp;
    end
  end

  pfs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_n(fault_n), .sync_n(flt_n_s)
  );

  pfs_fault_ctrl u_ctrl (
    .clk(clk), .rst(rst), .flt_n_s(flt_n_s), .bnd(pwm_bnd),
    .mode(mode_q), .flag_clr(flag_clr), .flag(flt_flag), .apply(apply)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pfs_pair_mux u_mux (
      .clk(clk), .rst(rst), .rst_tristate(rst_tristate),
      .pol_h(pol_hi), .pol_l(pol_lo),
      .raw_h(pwm_raw[2*p]), .raw_l(pwm_raw[2*p+1]),
      .en_h(pin_en_q[2*p]), .en_l(pin_en_q[2*p+1]),
      .ovr(apply & pair_en_q[p]),
      .lvl_h(lvl_q[2*p]), .lvl_l(lvl_q[2*p+1]),
      .comp(comp_q),
      .out_h(pin_out[2*p]), .out_l(pin_out[2*p+1]),
      .oe_h(pin_oe[2*p]), .oe_l(pin_oe[2*p+1])
    );
  end

  // R4: with no pair enabled the pins follow the raw path
  p_no_pair_r4: assert property (@(posedge clk) disable iff (rst)
    (pair_en_q == '0 && pin_en_q == '1) |=>
      (pin_out == ($past(pwm_raw) ^ ~{NPAIR{$past(pol_lo), $past(pol_hi)}})));
endmodule

// File: tb/tb_pwm_fault_stage.sv
module tb_pwm_fault_stage;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rst_tristate = 1'b1;
  logic       pol_hi = 1'b1, pol_lo = 1'b1;
  logic [5:0] pwm_raw = '0;
  logic       pwm_bnd = 1'b0;
  logic       fault_n = 1'b1;
  logic       cfg_we = 1'b0;
  logic [5:0] cfg_pin_en = '0;
  logic [2:0] cfg_flt_pair_en = '0;
  logic [5:0] cfg_flt_lvl = '0;
  logic       cfg_latched = 1'b0, cfg_comp = 1'b0;
  logic       flag_clr = 1'b0;
  logic [5:0] pin_out, pin_oe;
  logic       flt_flag;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pwm_fault_stage dut (
    .clk(clk), .rst(rst), .rst_tristate(rst_tristate),
    .pol_hi(pol_hi), .pol_lo(pol_lo), .pwm_raw(pwm_raw), .pwm_bnd(pwm_bnd),
    .fault_n(fault_n), .cfg_we(cfg_we), .cfg_pin_en(cfg_pin_en),
    .cfg_flt_pair_en(cfg_flt_pair_en), .cfg_flt_lvl(cfg_flt_lvl),
    .cfg_latched(cfg_latched), .cfg_comp(cfg_comp), .flag_clr(flag_clr),
    .pin_out(pin_out), .pin_oe(pin_oe), .flt_flag(flt_flag)
  );

  // {raw, pol_hi, pol_lo, expected pin_out}
  localparam logic [13:0] VEC [5] = '{
    {6'b000000, 1'b1, 1'b1, 6'b000000},
    {6'b101010, 1'b1, 1'b1, 6'b101010},
    {6'b101010, 1'b0, 1'b0, 6'b010101},
    {6'b110011, 1'b1, 1'b0, 6'b011001},
    {6'b111111, 1'b0, 1'b1, 6'b101010}
  };

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [5:0] pen, input logic [2:0] fen,
                     input logic [5:0] lvl, input logic lat, input logic cmp);
    cfg_pin_en = pen; cfg_flt_pair_en = fen; cfg_flt_lvl = lvl;
    cfg_latched = lat; cfg_comp = cmp; cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic pulse_bnd();
    pwm_bnd = 1'b1; step(); pwm_bnd = 1'b0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1; step(); flag_clr = 1'b0;
  endtask

  task automatic recover();
    fault_n = 1'b1; step(3);
    pulse_clr(); pulse_bnd(); step();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    // R1: tri-state reset option
    #1; step(2);
    chk("R1 oe in reset, tristate", pin_oe, 6'b000000);
    chk("R1 out in reset", pin_out, 6'b000000);
    rst = 1'b0; step();
    chk("R1 oe after reset, tristate", pin_oe, 6'b000000);
    // R1: drive-inactive reset option, low side active-low
    rst_tristate = 1'b0; pol_lo = 1'b0; rst = 1'b1; step(2);
    chk("R1 oe in reset, driven", pin_oe, 6'b111111);
    chk("R1 out inactive in reset", pin_out, 6'b101010);
    rst = 1'b0; step();
    chk("R1 oe after reset, driven", pin_oe, 6'b111111);

    // R2: polarity table
    foreach (VEC[i]) begin
      pwm_raw = VEC[i][13:8]; pol_hi = VEC[i][7]; pol_lo = VEC[i][6];
      step();
      chk($sformatf("R2 vector %0d", i), pin_out, VEC[i][5:0]);
    end
    pol_hi = 1'b1; pol_lo = 1'b1;

    // R3: pin enables
    pwm_raw = 6'b111111;
    cfg(6'b011110, 3'b000, 6'b000000, 1'b0, 1'b0);
    step();
    chk("R3 oe per pin", pin_oe, 6'b011110);
    chk("R3 disabled pins inactive", pin_out, 6'b011110);
    pwm_raw = 6'b000000;

    // R5/R9/R10: cycle-by-cycle mode
    cfg(6'b111111, 3'b011, 6'b111101, 1'b0, 1'b0);
    step();
    fault_n = 1'b0;
    step(2);
    chk("R5 not yet forced at edge 2", pin_out, 6'b000000);
    step();
    chk("R5 forced levels at edge 3", pin_out, 6'b001101);
    chk("R10 flag set", {5'b0, flt_flag}, 6'b000001);
    fault_n = 1'b1; step(5);
    chk("R9 held until boundary", pin_out, 6'b001101);
    pulse_bnd();
    chk("R9 still forced at boundary edge", pin_out, 6'b001101);
    step();
    chk("R9 normal after boundary", pin_out, 6'b000000);
    chk("R10 flag stays set", {5'b0, flt_flag}, 6'b000001);
    pulse_clr();
    chk("R10 flag cleared", {5'b0, flt_flag}, 6'b000000);

    // R6: complementary priority
    cfg(6'b111111, 3'b011, 6'b111101, 1'b0, 1'b1);
    fault_n = 1'b0; step(4);
    chk("R6 low side held inactive", pin_out, 6'b000101);
    recover();
    chk("R6 recovered", pin_out, 6'b000000);

    // R7: latched release needs pin high, flag clear and boundary
    cfg(6'b111111, 3'b011, 6'b111101, 1'b1, 1'b0);
    fault_n = 1'b0; step(4);
    chk("R7 forced in latched mode", pin_out, 6'b001101);
    fault_n = 1'b1; step(3);
    pulse_bnd(); step();
    chk("R7 held while flag set", pin_out, 6'b001101);
    pulse_clr(); step();
    chk("R7 held until boundary", pin_out, 6'b001101);
    pulse_bnd(); step();
    chk("R7 normal after boundary", pin_out, 6'b000000);

    // R8: flag cleared while pin still low
    fault_n = 1'b0; step(4);
    chk("R8 flag set again", {5'b0, flt_flag}, 6'b000001);
    pulse_clr();
    pulse_bnd(); step();
    chk("R8 held while pin low", pin_out, 6'b001101);
    fault_n = 1'b1; step(4);
    chk("R8 held after rise without boundary", pin_out, 6'b001101);
    pulse_bnd(); step();
    chk("R8 normal after boundary", pin_out, 6'b000000);

    // R10: set and clear in the same cycle
    chk("R10 flag clear before race", {5'b0, flt_flag}, 6'b000000);
    fault_n = 1'b0; step(2);
    flag_clr = 1'b1; step(); flag_clr = 1'b0;
    chk("R10 set wins over clear", {5'b0, flt_flag}, 6'b000001);
    recover();

    // R4: no pair enabled, flag still works
    cfg(6'b111111, 3'b000, 6'b111111, 1'b0, 1'b0);
    pwm_raw = 6'b101010;
    fault_n = 1'b0; step(4);
    chk("R4 outputs unaffected", pin_out, 6'b101010);
    chk("R10 flag set with no pair enabled", {5'b0, flt_flag}, 6'b000001);
    recover();

    finish_run();
  end
endmodule